// File: doc/BRIEF.md
# Interrupt Vector Aggregation Controller

This block gathers a wide bus of edge-signalled interrupt vectors into latched pending bits. Each vector has an enable bit. The block reports the vectors that are both pending and enabled on a small set of level outputs, which go to a higher-level interrupt controller. Vectors are grouped into 32-bit words. Each word has one pending register, one enable register and one parent output line.

Software reaches the block through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and registered read data. A handler reads a pending word and writes the same value back to acknowledge every bit in it at once. It then services the bits it saw. Masking and unmasking use read-modify-write cycles on the enable words. The block does no priority encoding: software scans the pending words itself.

Top module: `ivac_top`

## Requirements
- R1: After synchronous reset, every pending bit and every enable bit is zero, every `irq_o` line is low, and every register reads as zero.
- R2: A 0-to-1 transition on `vec_i[n]` between two consecutive clock edges sets pending bit n at that edge, whether or not vector n is enabled. An input held high does not set the bit again after it has been cleared.
- R3: Vector n lives in word n/32 at bit n%32. The pending word for group g is at byte offset 4*g (0x00, 0x04, 0x08, 0x0C).
- R4: A write to a pending word clears each pending bit whose write-data bit is one. Bits written as zero keep their value.
- R5: When a new rising edge and a write-one-to-clear hit the same pending bit at the same edge, the bit ends up set.
- R6: The enable word for group g is at byte offset 0x20 + 4*g. A write stores the data; a one unmasks the vector and a zero masks it. A read returns the stored mask.
- R7: `irq_o[g]` is a registered level. It equals the OR over group g of (pending AND enable) as that state stood before the previous clock edge, so it rises one cycle after the pending bit is set.
- R8: Reads of an unmapped or misaligned byte address (any address with bits [1:0] not zero, 0x10 to 0x1F, and 0x30 and above) return zero. Writes to such an address change no pending or enable bit.
- R9: `rdata_o` is registered. After a clock edge it holds the register that `addr_i` selected at that edge, with the value the register had before that edge's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 8 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| vec_i | input | 128 | Interrupt vector inputs, rising-edge sensitive |
| irq_o | output | 4 | Parent interrupt lines, one per 32-vector group |

## Verification
The hardest case to reach from the ports is a rising edge on a vector in the same cycle that software writes a one to that vector's pending bit. The edge must win. The bench drives this collision on purpose for single bits and for a full-word acknowledge. The random phase raises its write rate on pending words while vectors toggle, so that the collision also happens by chance many times. A second case that is hard to reach is a vector held high across a clear. The bench keeps a vector high for several cycles after acknowledging it, to show that no spurious re-latch happens.

// File: rtl/ivac_pkg.sv
package ivac_pkg;
  // Kind of register an address selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_EN   = 2'd2
  } ivac_sel_e;

  // Byte address to word index
  function automatic int unsigned word_of(input int unsigned byte_addr);
    return byte_addr / 4;
  endfunction
endpackage

// File: rtl/ivac_edge.sv
// Rising-edge detector for the vector input bus
module ivac_edge #(
  parameter int unsigned N = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (rst) vec_q <= '0;
    else     vec_q <= vec_i;
  end

  assign rise_o = vec_i & ~vec_q;
endmodule

// File: rtl/ivac_decode.sv
// Address decoder: one-hot hits for pending and enable words
module ivac_decode #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned EN_OFFSET  = 32
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NUM_GROUPS-1:0] hit_pend_o,
  output logic [NUM_GROUPS-1:0] hit_en_o,
  output ivac_pkg::ivac_sel_e   sel_o
);
  localparam int unsigned WORD_W  = ADDR_W - 2;
  localparam int unsigned EN_WORD = ivac_pkg::word_of(EN_OFFSET);

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hit
    assign hit_pend_o[g] = aligned && (word == WORD_W'(g));
    assign hit_en_o[g]   = aligned && (word == WORD_W'(EN_WORD + g));
  end

  always_comb begin
    if (|hit_pend_o)    sel_o = ivac_pkg::SEL_PEND;
    else if (|hit_en_o) sel_o = ivac_pkg::SEL_EN;
    else                sel_o = ivac_pkg::SEL_NONE;
  end
endmodule

// File: rtl/ivac_group.sv
// One group of vectors: pending word, enable word, parent line
module ivac_group #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      en_o   <= '0;
      irq_o  <= 1'b0;
    end else begin
      // new edges are ORed in after the clear, so they win a collision
      pend_o <= (pend_o & ~clr_i) | rise_i;
      if (en_we_i) en_o <= en_wdata_i;
      irq_o  <= |(pend_o & en_o);
    end
  end
endmodule

// File: rtl/ivac_top.sv
module ivac_top #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned GROUP_W    = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned EN_OFFSET  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          wr_en_i,
  input  logic [GROUP_W-1:0]            wdata_i,
  output logic [GROUP_W-1:0]            rdata_o,
  input  logic [NUM_GROUPS*GROUP_W-1:0] vec_i,
  output logic [NUM_GROUPS-1:0]         irq_o
);
  localparam int unsigned NUM_VEC = NUM_GROUPS * GROUP_W;

  logic [NUM_VEC-1:0]                   rise;
  logic [NUM_GROUPS-1:0]                hit_pend;
  logic [NUM_GROUPS-1:0]                hit_en;
  ivac_pkg::ivac_sel_e                  sel;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0]   pend_w;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0]   en_w;
  logic [NUM_VEC-1:0]                   pend_all;
  logic [NUM_VEC-1:0]                   en_all;
  logic [GROUP_W-1:0]                   rd_next;

  ivac_edge #(.N(NUM_VEC)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .vec_i  (vec_i),
    .rise_o (rise)
  );

  ivac_decode #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W),
    .EN_OFFSET  (EN_OFFSET)
  ) u_dec (
    .addr_i     (addr_i),
    .hit_pend_o (hit_pend),
    .hit_en_o   (hit_en),
    .sel_o      (sel)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [GROUP_W-1:0] clr;
    assign clr = (wr_en_i && hit_pend[g]) ? wdata_i : '0;

    ivac_group #(.W(GROUP_W)) u_grp (
      .clk        (clk),
      .rst        (rst),
      .rise_i     (rise[g*GROUP_W +: GROUP_W]),
      .clr_i      (clr),
      .en_we_i    (wr_en_i && hit_en[g]),
      .en_wdata_i (wdata_i),
      .pend_o     (pend_w[g]),
      .en_o       (en_w[g]),
      .irq_o      (irq_o[g])
    );
  end

  assign pend_all = pend_w;
  assign en_all   = en_w;

  // read mux over the one-hot hits
  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel == ivac_pkg::SEL_PEND && hit_pend[g]) rd_next = pend_w[g];
      if (sel == ivac_pkg::SEL_EN && hit_en[g])     rd_next = en_w[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end
endmodule

// File: rtl/ivac_checker.sv
module ivac_checker #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned GROUP_W    = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned EN_OFFSET  = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [ADDR_W-1:0]             addr_i,
  input logic                          wr_en_i,
  input logic [GROUP_W-1:0]            wdata_i,
  input logic [NUM_GROUPS*GROUP_W-1:0] vec_i,
  input logic [NUM_GROUPS-1:0]         irq_o,
  input logic [NUM_GROUPS*GROUP_W-1:0] pend_all,
  input logic [NUM_GROUPS*GROUP_W-1:0] en_all
);
  localparam int unsigned NUM_VEC = NUM_GROUPS * GROUP_W;
  localparam int unsigned EN_WORD = EN_OFFSET / 4;

  logic [NUM_VEC-1:0]    vin_q;
  logic [NUM_VEC-1:0]    rise_obs;
  logic [NUM_GROUPS-1:0] live;
  logic                  rst_d;
  logic                  mapped;
  int unsigned           word;

  always_ff @(posedge clk) begin
    if (rst) vin_q <= '0;
    else     vin_q <= vec_i;
  end
  assign rise_obs = vec_i & ~vin_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_live
    assign live[g] = |(pend_all[g*GROUP_W +: GROUP_W] & en_all[g*GROUP_W +: GROUP_W]);
  end

  assign word   = int'(addr_i) / 4;
  assign mapped = (addr_i[1:0] == 2'b00) &&
                  ((word < NUM_GROUPS) || (word >= EN_WORD && word < EN_WORD + NUM_GROUPS));

  always_ff @(posedge clk) begin
    rst_d <= rst;
    // R1: state is quiet right after reset is released
    if (rst_d && !rst)
      p_reset_quiet_r1: assert (irq_o == '0 && pend_all == '0 && en_all == '0);
  end

  p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_all & $past(rise_obs)) == $past(rise_obs)));

  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(live)));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !mapped) |=> $stable(en_all));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_prop
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && addr_i == ADDR_W'(4 * g)) |=>
      ((pend_all[g*GROUP_W +: GROUP_W] &
        $past(wdata_i & ~rise_obs[g*GROUP_W +: GROUP_W])) == '0));

    p_en_write_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && addr_i == ADDR_W'(EN_OFFSET + 4 * g)) |=>
      (en_all[g*GROUP_W +: GROUP_W] == $past(wdata_i)));
  end
endmodule

bind ivac_top ivac_checker #(
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_W    (GROUP_W),
  .ADDR_W     (ADDR_W),
  .EN_OFFSET  (EN_OFFSET)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .wdata_i  (wdata_i),
  .vec_i    (vec_i),
  .irq_o    (irq_o),
  .pend_all (pend_all),
  .en_all   (en_all)
);

// File: tb/ivac_top_tb.sv
module ivac_top_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] vec = '0;
  logic [3:0]   irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [31:0]  m_pend [4];
  logic [31:0]  m_en   [4];
  logic [127:0] m_prev;

  always #5 clk = ~clk;

  ivac_top u_dut (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .vec_i   (vec),
    .irq_o   (irq)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    for (int g = 0; g < 4; g++) begin
      if (a == 8'(4 * g))        return m_pend[g];
      if (a == 8'(8'h20 + 4 * g)) return m_en[g];
    end
    return '0;
  endfunction

  function automatic logic [3:0] model_irq();
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |(m_pend[g] & m_en[g]);
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle; checks rdata (R9 plus tag) and irq (R7)
  task automatic tick(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [127:0] v, input string tag);
    logic [31:0]  exp_rd;
    logic [3:0]   exp_irq;
    logic [127:0] rise;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; vec = v;
    exp_rd  = model_read(a);
    exp_irq = model_irq();
    rise    = v & ~m_prev;
    for (int g = 0; g < 4; g++) begin
      if (we && a == 8'(4 * g)) m_pend[g] = m_pend[g] & ~d;
      m_pend[g] = m_pend[g] | rise[g*32 +: 32];
      if (we && a == 8'(8'h20 + 4 * g)) m_en[g] = d;
    end
    m_prev = v;
    @(posedge clk); #1;
    chk(rdata, exp_rd, {tag, " R9 rdata"});
    chk({28'd0, irq}, {28'd0, exp_irq}, {tag, " R7 irq"});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    tick(1'b0, a, '0, vec, tag);
    tick(1'b0, a, '0, vec, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    void'($urandom(32'd1234));
    for (int g = 0; g < 4; g++) begin m_pend[g] = '0; m_en[g] = '0; end
    m_prev = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(rdata, 32'h0, "R1 rdata after reset");
    chk({28'd0, irq}, 32'h0, "R1 irq after reset");
    // R1: every register zero
    for (int g = 0; g < 4; g++) begin
      rd(8'(4 * g), "R1 pend");
      rd(8'(8'h20 + 4 * g), "R1 en");
    end

    // R6: enable write and readback
    tick(1'b1, 8'h20, 32'hA5A5_0F0F, vec, "R6 wr en0");
    tick(1'b1, 8'h2C, 32'h8000_0001, vec, "R6 wr en3");
    rd(8'h20, "R6 rd en0");
    rd(8'h2C, "R6 rd en3");

    // R3/R2: vector 37 -> word 1 bit 5, masked
    v = vec; v[37] = 1'b1;
    tick(1'b0, 8'h04, '0, v, "R2 edge 37 masked");
    rd(8'h04, "R3 vec37 word1 bit5");
    // R7: unmask -> irq[1]
    tick(1'b1, 8'h24, 32'h0000_0020, vec, "R7 unmask 37");
    rd(8'h00, "R7 irq1 high");
    // R2: held high, clear, no re-latch
    tick(1'b1, 8'h04, 32'h0000_0020, vec, "R4 clear 37");
    repeat (3) tick(1'b0, 8'h04, '0, vec, "R2 held high no relatch");
    // vectors 0 and 127
    v = vec; v[0] = 1'b1; v[127] = 1'b1;
    tick(1'b0, 8'h00, '0, v, "R3 edges 0,127");
    rd(8'h00, "R3 vec0");
    rd(8'h0C, "R3 vec127 irq3");
    // R4: partial clear
    v = vec; v[100] = 1'b1; v[101] = 1'b1;
    tick(1'b0, 8'h0C, '0, v, "R2 edges 100,101");
    tick(1'b1, 8'h0C, 32'h0000_0010, vec, "R4 partial clear");
    rd(8'h0C, "R4 other bits kept");
    // R5: collision edge vs full-word clear
    v = vec; v[37] = 1'b0; v[40] = 1'b0;
    tick(1'b0, 8'h04, '0, v, "R5 prep low");
    v[37] = 1'b1; v[40] = 1'b1;
    tick(1'b1, 8'h04, 32'hFFFF_FFFF, v, "R5 edge+clear");
    rd(8'h04, "R5 edge wins");
    // R8: unmapped writes and reads
    tick(1'b1, 8'h10, 32'hFFFF_FFFF, vec, "R8 wr 0x10");
    tick(1'b1, 8'h30, 32'hFFFF_FFFF, vec, "R8 wr 0x30");
    tick(1'b1, 8'h21, 32'hFFFF_FFFF, vec, "R8 wr 0x21");
    tick(1'b1, 8'h05, 32'hFFFF_FFFF, vec, "R8 wr 0x05");
    rd(8'h10, "R8 rd 0x10");
    rd(8'h22, "R8 rd 0x22");
    rd(8'hFC, "R8 rd 0xFC");
    for (int g = 0; g < 4; g++) begin
      rd(8'(4 * g), "R8 pend untouched");
      rd(8'(8'h20 + 4 * g), "R8 en untouched");
    end

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        we;
      int          k;
      v = vec;
      for (int t = 0; t < 3; t++) v[$urandom_range(127, 0)] ^= 1'b1;
      k  = $urandom_range(11, 0);
      if (k < 4)       a = 8'(4 * k);
      else if (k < 8)  a = 8'(8'h20 + 4 * (k - 4));
      else if (k == 8) a = 8'h14;
      else if (k == 9) a = 8'h3C;
      else if (k == 10) a = 8'h02;
      else             a = 8'(4 * $urandom_range(3, 0));
      we = ($urandom_range(2, 0) != 0);
      d  = ($urandom_range(3, 0) == 0) ? 32'hFFFF_FFFF : $urandom;
      tick(we, a, d, v, "R2 R4 R5 R6 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule